// File: doc/BRIEF.md
# Processor Interrupt Interface with Split Completion

This block sits between an interrupt distributor and one processor. The distributor presents its most urgent pending interrupt as an ID and a priority. The block decides whether that interrupt may be signalled, based on a software priority threshold, the priority of the interrupt already being serviced, and a global enable. If it may, the block raises an interrupt line to the processor. Software claims the interrupt by reading an acknowledge register. That read returns the ID and tells the distributor, through a one-cycle pulse, to mark the interrupt active.

Software completes an interrupt by writing its ID back to an end-of-interrupt register. In combined mode that write lowers the running priority to idle and also tells the distributor to clear the active state. In split mode the same write only lowers the running priority. A later write to a separate deactivate register clears the active state. A hypervisor can use this to keep an interrupt active after the host has finished with it. The block holds one running-priority level, so it does not nest preemptions.

The register port uses a 3-bit word address. The encodings are: 0 control, 1 priority mask, 2 acknowledge (read), 3 end-of-interrupt (write), 4 deactivate (write), 5 running priority (read). Read data is combinational in the access cycle. Side effects take place at the clock edge that ends the access.

Top module: `cpu_irq_iface`

## Requirements
- R1: A read at address 2 while an interrupt is eligible returns its ID in bits 9:0, with the upper bits zero. In the following cycle, `actSet` is high for exactly one cycle and `actSetId` carries that ID.
- R2: A read at address 2 while nothing is eligible returns 1023 and produces no `actSet` pulse. A presented ID above 1019 is never eligible.
- R3: An interrupt is eligible only if its priority is numerically strictly below the priority mask (address 1, bits 7:0). The mask resets to 0, so nothing is signalled after reset.
- R4: A successful acknowledge sets the running priority to the acknowledged priority. Afterwards an interrupt is eligible only if its priority is strictly below the running priority. The running priority reads at address 5 and resets to 0xFF (idle).
- R5: In combined mode (control bit 1 = 0), an end-of-interrupt write whose bits 9:0 match the running ID, while the running priority is not idle, does two things. It returns the running priority to 0xFF, and in the next cycle it pulses `actClr` for one cycle with that ID.
- R6: In split mode (control bit 1 = 1), a matching end-of-interrupt write returns the running priority to 0xFF with no `actClr` pulse. A deactivate write with an ID of at most 1019 pulses `actClr` with that ID in the next cycle.
- R7: The following writes have no effect on the running priority or on `actClr`: an end-of-interrupt write whose ID does not match, a deactivate write in combined mode, and a deactivate write with an ID above 1019.
- R8: Control bit 0 enables signalling. When it is 0, `irqOut` stays low and an acknowledge read returns 1023.
- R9: Control bits 5:2 are bypass-disable bits. They are stored exactly as written, read back at address 0 along with bits 1:0, and reset to 0.
- R10: `irqOut` is high exactly when an interrupt is eligible: the presented interrupt is valid, the block is enabled, the ID is at most 1019, and the priority is below both the mask and the running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| bestValid | input | 1 | Distributor has a pending candidate |
| bestId | input | 10 | Candidate interrupt ID |
| bestPrio | input | 8 | Candidate priority, lower is more urgent |
| actSet | output | 1 | Pulse: mark `actSetId` active |
| actSetId | output | 10 | ID to mark active |
| actClr | output | 1 | Pulse: mark `actClrId` inactive |
| actClrId | output | 10 | ID to mark inactive |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Every cycle, the assertions check the following. An `actSet` pulse only ever follows an acknowledge read and carries a real ID. An `actClr` pulse only follows a completion or deactivate write. An acknowledge read returns either the presented ID or 1023, depending on `irqOut`. After an acknowledge, the line can only stay high for a strictly more urgent candidate. Some behaviour depends on register history, and only the bench scenarios show it: the difference between split and combined completion, ignored completions with the wrong ID, the strict comparisons at the mask and running-priority boundaries, and the bypass bits surviving a rewrite of the control register.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_PMASK   = 3'd1,
    REG_ACK     = 3'd2,
    REG_EOI     = 3'd3,
    REG_DEACT   = 3'd4,
    REG_RUNPRIO = 3'd5,
    REG_NONE6   = 3'd6,
    REG_NONE7   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic ctrlWr;
    logic maskWr;
    logic ackRd;
    logic eoiWr;
    logic deactWr;
  } strobes_t;
endpackage

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl
  import cpu_irq_pkg::*;
(
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          strb,
  output regSel_e           rdSel
);
  regSel_e sel;

  always_comb begin
    sel          = regSel_e'(regAddr);
    rdSel        = sel;
    strb         = '0;
    strb.ctrlWr  = regValid &&  regWrite && (sel == REG_CTRL);
    strb.maskWr  = regValid &&  regWrite && (sel == REG_PMASK);
    strb.ackRd   = regValid && !regWrite && (sel == REG_ACK);
    strb.eoiWr   = regValid &&  regWrite && (sel == REG_EOI);
    strb.deactWr = regValid &&  regWrite && (sel == REG_DEACT);
  end
endmodule

// File: rtl/cpu_irq_dp.sv
module cpu_irq_dp
  import cpu_irq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  parameter int BYP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              bestValid,
  input  logic [ID_W-1:0]   bestId,
  input  logic [PRIO_W-1:0] bestPrio,
  output logic              actSet,
  output logic [ID_W-1:0]   actSetId,
  output logic              actClr,
  output logic [ID_W-1:0]   actClrId,
  output logic              irqOut
);
  localparam logic [ID_W-1:0]   SPUR_ID   = {ID_W{1'b1}};
  localparam logic [ID_W-1:0]   LAST_REAL = SPUR_ID - ID_W'(4);
  localparam logic [PRIO_W-1:0] IDLE_PRIO = {PRIO_W{1'b1}};
  localparam int CTL_EN     = 0;
  localparam int CTL_SPLIT  = 1;
  localparam int CTL_BYP_LO = 2;
  localparam int CTL_PAD    = DATA_W - BYP_W - 2;

  logic              enableQ, splitQ;
  logic [BYP_W-1:0]  bypQ;
  logic [PRIO_W-1:0] maskQ, runPrioQ;
  logic [ID_W-1:0]   runIdQ;
  logic              setQ, clrQ;
  logic [ID_W-1:0]   setIdQ, clrIdQ;

  logic            eligible, eoiHit, deactOk;
  logic [ID_W-1:0] wrId, ackId;

  always_comb begin
    wrId     = regWdata[ID_W-1:0];
    eligible = bestValid && enableQ && (bestId <= LAST_REAL) &&
               (bestPrio < maskQ) && (bestPrio < runPrioQ);
    ackId    = eligible ? bestId : SPUR_ID;
    eoiHit   = strb.eoiWr && (runPrioQ != IDLE_PRIO) && (wrId == runIdQ);
    deactOk  = strb.deactWr && splitQ && (wrId <= LAST_REAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      splitQ   <= 1'b0;
      bypQ     <= '0;
      maskQ    <= '0;
      runPrioQ <= IDLE_PRIO;
      runIdQ   <= '0;
      setQ     <= 1'b0;
      setIdQ   <= '0;
      clrQ     <= 1'b0;
      clrIdQ   <= '0;
    end else begin
      setQ <= 1'b0;
      clrQ <= 1'b0;
      if (strb.ctrlWr) begin
        enableQ <= regWdata[CTL_EN];
        splitQ  <= regWdata[CTL_SPLIT];
        bypQ    <= regWdata[CTL_BYP_LO +: BYP_W];
      end
      if (strb.maskWr) maskQ <= regWdata[PRIO_W-1:0];
      if (strb.ackRd && eligible) begin
        runPrioQ <= bestPrio;
        runIdQ   <= bestId;
        setQ     <= 1'b1;
        setIdQ   <= bestId;
      end
      if (eoiHit) begin
        runPrioQ <= IDLE_PRIO;
        if (!splitQ) begin
          clrQ   <= 1'b1;
          clrIdQ <= wrId;
        end
      end
      if (deactOk) begin
        clrQ   <= 1'b1;
        clrIdQ <= wrId;
      end
    end
  end

  always_comb begin
    case (rdSel)
      REG_CTRL:    regRdata = {{CTL_PAD{1'b0}}, bypQ, splitQ, enableQ};
      REG_PMASK:   regRdata = DATA_W'(maskQ);
      REG_ACK:     regRdata = DATA_W'(ackId);
      REG_RUNPRIO: regRdata = DATA_W'(runPrioQ);
      default:     regRdata = '0;
    endcase
  end

  assign actSet   = setQ;
  assign actSetId = setIdQ;
  assign actClr   = clrQ;
  assign actClrId = clrIdQ;
  assign irqOut   = eligible;
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  parameter int BYP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              bestValid,
  input  logic [ID_W-1:0]   bestId,
  input  logic [PRIO_W-1:0] bestPrio,
  output logic              actSet,
  output logic [ID_W-1:0]   actSetId,
  output logic              actClr,
  output logic [ID_W-1:0]   actClrId,
  output logic              irqOut
);
  strobes_t strb;
  regSel_e  rdSel;

  cpu_irq_ctrl u_ctrl (
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .strb(strb), .rdSel(rdSel)
  );

  cpu_irq_dp #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .BYP_W(BYP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .regWdata(regWdata), .regRdata(regRdata),
    .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio),
    .actSet(actSet), .actSetId(actSetId), .actClr(actClr), .actClrId(actClrId),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/cpu_irq_chk.sv
module cpu_irq_chk #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              bestValid,
  input logic [ID_W-1:0]   bestId,
  input logic [PRIO_W-1:0] bestPrio,
  input logic              actSet,
  input logic [ID_W-1:0]   actSetId,
  input logic              actClr,
  input logic              irqOut
);
  localparam logic [ID_W-1:0] SPUR_ID   = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] LAST_REAL = SPUR_ID - ID_W'(4);

  logic ackRead, doneWrite;
  assign ackRead   = regValid && !regWrite && (regAddr == 3'd2);
  assign doneWrite = regValid &&  regWrite && ((regAddr == 3'd3) || (regAddr == 3'd4));

  // R1
  ack_returns_best_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && irqOut) |-> (regRdata == DATA_W'(bestId)));
  // R1
  set_follows_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    actSet |-> $past(ackRead && irqOut));
  // R2
  spurious_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !irqOut) |-> (regRdata == DATA_W'(SPUR_ID)));
  // R2
  no_set_on_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !irqOut) |=> !actSet);
  // R2
  set_real_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    actSet |-> (actSetId <= LAST_REAL));
  // R5
  clr_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    actClr |-> $past(doneWrite));
  // R4
  irq_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && irqOut) |=> (!irqOut || (bestPrio < $past(bestPrio))));
  // R10
  irq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> bestValid);
endmodule

bind cpu_irq_iface cpu_irq_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
  .regRdata(regRdata), .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio),
  .actSet(actSet), .actSetId(actSetId), .actClr(actClr), .irqOut(irqOut)
);

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regValid, regWrite;
  logic [2:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        bestValid;
  logic [9:0]  bestId;
  logic [7:0]  bestPrio;
  logic        actSet, actClr, irqOut;
  logic [9:0]  actSetId, actClrId;

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  int mEn = 0, mSplit = 0, mByp = 0, mMask = 0, mRun = 255, mRunId = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_iface u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio),
    .actSet(actSet), .actSetId(actSetId), .actClr(actClr), .actClrId(actClrId),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one access cycle; entered and left just after a falling edge
  task automatic cyc(input bit v, input bit w, input int a, input int d,
                     input bit bv, input int bid, input int bp, input string tag);
    bit elig;
    int expRd;
    bit expSet, expClr;
    int expSetId, expClrId;
    regValid = v; regWrite = w; regAddr = 3'(a); regWdata = 32'(d);
    bestValid = bv; bestId = 10'(bid); bestPrio = 8'(bp);
    #1;
    elig = bv && (mEn != 0) && (bid <= 1019) && (bp < mMask) && (bp < mRun);
    check({tag, " R10 irqOut"}, irqOut, elig);
    if (v && !w) begin
      case (a)
        0: expRd = (mByp << 2) | (mSplit << 1) | mEn;
        1: expRd = mMask;
        2: expRd = elig ? bid : 1023;
        5: expRd = mRun;
        default: expRd = 0;
      endcase
      check({tag, " read data"}, regRdata, expRd);
    end
    expSet = 0; expClr = 0; expSetId = 0; expClrId = 0;
    if (v && !w && a == 2 && elig) begin
      expSet = 1; expSetId = bid; mRun = bp; mRunId = bid;
    end
    if (v && w) begin
      case (a)
        0: begin mEn = d & 1; mSplit = (d >> 1) & 1; mByp = (d >> 2) & 15; end
        1: mMask = d & 255;
        3: if (mRun != 255 && (d & 1023) == mRunId) begin
             mRun = 255;
             if (mSplit == 0) begin expClr = 1; expClrId = d & 1023; end
           end
        4: if (mSplit != 0 && (d & 1023) <= 1019) begin expClr = 1; expClrId = d & 1023; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " actSet"}, actSet, expSet);
    if (expSet) check({tag, " actSetId"}, actSetId, expSetId);
    check({tag, " actClr"}, actClr, expClr);
    if (expClr) check({tag, " actClrId"}, actClrId, expClrId);
  endtask

  task automatic rd(input int a, input bit bv, input int bid, input int bp, input string tag);
    cyc(1, 0, a, 0, bv, bid, bp, tag);
  endtask
  task automatic wr(input int a, input int d, input bit bv, input int bid, input int bp, input string tag);
    cyc(1, 1, a, d, bv, bid, bp, tag);
  endtask
  task automatic idle(input bit bv, input int bid, input int bp, input string tag);
    cyc(0, 0, 0, 0, bv, bid, bp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regValid = 0; regWrite = 0; regAddr = 0; regWdata = 0;
    bestValid = 0; bestId = 0; bestPrio = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // reset state
    rd(5, 0, 0, 0, "R4 reset runprio");
    rd(0, 0, 0, 0, "R9 reset ctrl");
    rd(1, 0, 0, 0, "R3 reset mask");
    // mask at zero blocks everything
    idle(1, 37, 8'h40, "R3 mask zero");
    wr(0, 1, 1, 37, 8'h40, "R8 enable");
    idle(1, 37, 8'h40, "R3 still masked");
    wr(1, 8'h80, 1, 37, 8'h40, "R3 set mask");
    idle(1, 37, 8'h80, "R3 equal to mask");
    idle(1, 37, 8'h7F, "R3 just below mask");
    // acknowledge
    rd(2, 1, 37, 8'h40, "R1 ack");
    idle(1, 37, 8'h40, "R4 same prio after ack");
    rd(5, 1, 37, 8'h40, "R4 runprio read");
    idle(1, 50, 8'h3F, "R4 more urgent");
    // completion, combined
    wr(3, 12, 1, 50, 8'h3F, "R7 eoi wrong id");
    rd(5, 0, 0, 0, "R7 runprio kept");
    wr(3, 37, 0, 0, 0, "R5 eoi combined");
    rd(5, 0, 0, 0, "R5 runprio idle");
    wr(3, 37, 0, 0, 0, "R7 eoi when idle");
    // spurious
    rd(2, 0, 5, 8'h10, "R2 ack nothing valid");
    idle(1, 1020, 8'h10, "R2 id 1020");
    rd(2, 1, 1020, 8'h10, "R2 ack id 1020");
    rd(2, 1, 1019, 8'h10, "R1 ack id 1019");
    wr(3, 1019, 0, 0, 0, "R5 eoi 1019");
    // split mode with bypass bits
    wr(0, 32'h2B, 0, 0, 0, "R6 split on");
    rd(0, 0, 0, 0, "R9 ctrl readback");
    rd(2, 1, 100, 8'h20, "R6 ack");
    wr(3, 100, 0, 0, 0, "R6 eoi split");
    rd(5, 0, 0, 0, "R6 runprio idle");
    wr(4, 1021, 0, 0, 0, "R7 deact bad id");
    wr(4, 100, 0, 0, 0, "R6 deact");
    // combined mode deactivate ignored
    wr(0, 32'h29, 0, 0, 0, "R9 rewrite mode");
    rd(0, 0, 0, 0, "R9 bypass kept");
    wr(4, 100, 0, 0, 0, "R7 deact combined");
    // disabled
    wr(0, 32'h28, 1, 7, 8'h01, "R8 disable");
    idle(1, 7, 8'h01, "R8 no irq");
    rd(2, 1, 7, 8'h01, "R8 ack spurious");
    rd(0, 0, 0, 0, "R9 ctrl disabled");
    wr(0, 32'h01, 1, 7, 8'h01, "R8 re-enable");
    rd(2, 1, 7, 8'h01, "R1 ack prio 1");
    idle(1, 8, 8'h00, "R4 prio 0 preempts");
    wr(3, 7, 0, 0, 0, "R5 finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule